// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block sits between a request source and a simplified multi-bank DRAM model. It accepts one access at a time through a valid/ready handshake. Each access names a bank, a row, a column and a direction. For every accepted access, the block issues the command sequence that the target bank needs. Every bank keeps its own open-row register. A request to the row that is already open goes straight to the column step. A request to a different row first closes the current row, then opens the new one, then issues the column command. A bank that has never opened a row skips the close step.

All banks share one narrow data bus. A bank that has reached its column step must first own the bus. Ownership starts with the column command and lasts until the last beat of the burst. When several banks wait, the bus goes to the bank that has waited longest. Close and open steps in other banks continue while a burst is in flight. The command strobes are one-cycle pulses, one bit per bank. The column strobe comes with the column address. The bus outputs show when burst beats are on the pins, and which bank and direction they belong to.

Top module: `dram_bank_sequencer`

## Requirements
- R1: After reset, every bank is idle with no open row. All strobes and `bus_busy` are low, and `req_ready` is high for every bank.
- R2: A request accepted by a bank with no open row gives no precharge. Its activate strobe pulses in the cycle after acceptance. The bank then waits for the bus T_ACT cycles after that pulse.
- R3: A request to a bank whose open row differs from the requested row pulses that bank's precharge strobe in the cycle after acceptance. The activate strobe follows T_PRE cycles after the precharge strobe.
- R4: A request to the open row of a bank gives no precharge and no activate. Its column strobe pulses in the cycle after it starts waiting for the bus, if the bus is free. `col_addr` carries the requested column while the column strobe is high, and zero otherwise.
- R5: Exactly T_CAS cycles after a column strobe, `bus_busy` rises for BURST consecutive cycles. During those cycles `bus_bank` names the bank and `bus_write` shows the request's write flag (1 = write). Both are zero when the bus is idle.
- R6: At most one bank owns the bus from its column strobe to its last beat. No column strobe occurs while another bank owns the bus.
- R7: When the bus becomes free, the bank that has waited longest receives the next column strobe. Banks that started waiting in the same cycle are served lowest index first.
- R8: `req_ready` shows whether the addressed bank is idle or holding an open row with no sequence in progress. A request to a bank in mid-sequence is held and not accepted.
- R9: Precharge and activate steps of one bank proceed while another bank's burst occupies the bus.
- R10: After its burst, a bank keeps the row open, so a following request to the same row is a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Addressed bank can accept |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_write | input | 1 | 1 = write access, 0 = read |
| pre_strobe | output | NUM_BANKS | Per-bank precharge command pulse |
| act_strobe | output | NUM_BANKS | Per-bank activate command pulse |
| col_strobe | output | NUM_BANKS | Per-bank column command pulse |
| col_addr | output | COL_W | Column of the bank pulsing its column strobe |
| bus_busy | output | 1 | Burst beat on the shared data pins |
| bus_bank | output | BANK_W | Bank owning the current beat |
| bus_write | output | 1 | Direction of the current beat |

## Verification
The bench builds the block with four banks and unequal short latencies: three cycles to close, two to open, two for the column step, and four-beat bursts. Because the latencies differ, a swapped or off-by-one counter moves a strobe to a visibly wrong cycle. Short phases let a few hundred random requests over three rows produce frequent row hits, misses and bus contention. This exercises the oldest-first bus order and close/open steps that overlap a running burst.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [2:0] {
        BK_IDLE,
        BK_PRECHARGE,
        BK_ACTIVATE,
        BK_OPEN,
        BK_WAIT_BUS,
        BK_COLUMN,
        BK_TRANSFER
    } bank_state_e;

    function automatic int idx_width(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    function automatic int timer_width(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return $clog2(m + 1);
    endfunction

endpackage

// File: rtl/dram_bank_fsm.sv
module dram_bank_fsm
    import dram_seq_pkg::*;
#(
    parameter int ROW_W = 14,
    parameter int COL_W = 8,
    parameter int T_PRE = 9,
    parameter int T_ACT = 9,
    parameter int T_CAS = 9,
    parameter int BURST = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic             req_write,
    input  logic             grant,
    output logic             ready,
    output logic             waiting,
    output logic             owns_bus,
    output logic             xfer,
    output logic             pre_s,
    output logic             act_s,
    output logic             col_s,
    output logic [COL_W-1:0] col_q,
    output logic             wr_q
);
    localparam int CNT_W = timer_width(T_PRE, T_ACT, T_CAS, BURST);
    localparam logic [CNT_W-1:0] PRE_FIRST = CNT_W'(T_PRE - 1);
    localparam logic [CNT_W-1:0] ACT_FIRST = CNT_W'(T_ACT - 1);
    localparam logic [CNT_W-1:0] CAS_FIRST = CNT_W'(T_CAS - 1);
    localparam logic [CNT_W-1:0] BST_FIRST = CNT_W'(BURST - 1);

    bank_state_e      state;
    logic [CNT_W-1:0] cnt;
    logic [ROW_W-1:0] open_row;
    logic             row_valid;
    logic             row_hit;

    assign row_hit  = row_valid && (open_row == req_row);
    assign ready    = (state == BK_IDLE) || (state == BK_OPEN);
    assign waiting  = (state == BK_WAIT_BUS);
    assign owns_bus = (state == BK_COLUMN) || (state == BK_TRANSFER);
    assign xfer     = (state == BK_TRANSFER);
    assign pre_s    = (state == BK_PRECHARGE) && (cnt == PRE_FIRST);
    assign act_s    = (state == BK_ACTIVATE) && (cnt == ACT_FIRST);
    assign col_s    = (state == BK_COLUMN) && (cnt == CAS_FIRST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= BK_IDLE;
            cnt       <= '0;
            open_row  <= '0;
            row_valid <= 1'b0;
            col_q     <= '0;
            wr_q      <= 1'b0;
        end else begin
            unique case (state)
                BK_IDLE, BK_OPEN: begin
                    if (accept) begin
                        open_row  <= req_row;
                        row_valid <= 1'b1;
                        col_q     <= req_col;
                        wr_q      <= req_write;
                        if (row_hit) begin
                            state <= BK_WAIT_BUS;
                        end else if (row_valid) begin
                            state <= BK_PRECHARGE;
                            cnt   <= PRE_FIRST;
                        end else begin
                            state <= BK_ACTIVATE;
                            cnt   <= ACT_FIRST;
                        end
                    end
                end
                BK_PRECHARGE: begin
                    if (cnt == '0) begin
                        state <= BK_ACTIVATE;
                        cnt   <= ACT_FIRST;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                BK_ACTIVATE: begin
                    if (cnt == '0) state <= BK_WAIT_BUS;
                    else           cnt   <= cnt - 1'b1;
                end
                BK_WAIT_BUS: begin
                    if (grant) begin
                        state <= BK_COLUMN;
                        cnt   <= CAS_FIRST;
                    end
                end
                BK_COLUMN: begin
                    if (cnt == '0) begin
                        state <= BK_TRANSFER;
                        cnt   <= BST_FIRST;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                BK_TRANSFER: begin
                    if (cnt == '0) state <= BK_OPEN;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= BK_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dram_bus_arbiter.sv
module dram_bus_arbiter
    import dram_seq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int AGE_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BANKS-1:0] waiting,
    input  logic                 bus_free,
    output logic [NUM_BANKS-1:0] grant
);
    localparam int IDX_W = idx_width(NUM_BANKS);

    logic [NUM_BANKS-1:0][AGE_W-1:0] age;
    logic [AGE_W-1:0]                best;
    logic [IDX_W-1:0]                pick;
    logic                            found;

    always_comb begin
        found = 1'b0;
        best  = '0;
        pick  = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (waiting[b] && (!found || age[b] > best)) begin
                found = 1'b1;
                best  = age[b];
                pick  = IDX_W'(b);
            end
        end
        grant = '0;
        if (found && bus_free) grant[pick] = 1'b1;
    end

    always_ff @(posedge clk) begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (rst || !waiting[b] || grant[b]) age[b] <= '0;
            else if (age[b] != '1)              age[b] <= age[b] + 1'b1;
        end
    end
endmodule

// File: rtl/dram_bank_sequencer.sv
module dram_bank_sequencer
    import dram_seq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 14,
    parameter int COL_W     = 8,
    parameter int T_PRE     = 9,
    parameter int T_ACT     = 9,
    parameter int T_CAS     = 9,
    parameter int BURST     = 8,
    parameter int AGE_W     = 8,
    localparam int BANK_W   = idx_width(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic [ROW_W-1:0]     req_row,
    input  logic [COL_W-1:0]     req_col,
    input  logic                 req_write,
    output logic [NUM_BANKS-1:0] pre_strobe,
    output logic [NUM_BANKS-1:0] act_strobe,
    output logic [NUM_BANKS-1:0] col_strobe,
    output logic [COL_W-1:0]     col_addr,
    output logic                 bus_busy,
    output logic [BANK_W-1:0]    bus_bank,
    output logic                 bus_write
);
    logic [NUM_BANKS-1:0]             bank_ready;
    logic [NUM_BANKS-1:0]             bank_wait;
    logic [NUM_BANKS-1:0]             bank_owns;
    logic [NUM_BANKS-1:0]             bank_xfer;
    logic [NUM_BANKS-1:0]             bank_wr;
    logic [NUM_BANKS-1:0]             grant;
    logic [NUM_BANKS-1:0]             accept;
    logic [NUM_BANKS-1:0][COL_W-1:0]  bank_col;

    always_comb begin
        req_ready = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (req_bank == BANK_W'(b)) req_ready = bank_ready[b];
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign accept[b] = req_valid && req_ready && (req_bank == BANK_W'(b));

        dram_bank_fsm #(
            .ROW_W (ROW_W),
            .COL_W (COL_W),
            .T_PRE (T_PRE),
            .T_ACT (T_ACT),
            .T_CAS (T_CAS),
            .BURST (BURST)
        ) u_bank (
            .clk       (clk),
            .rst       (rst),
            .accept    (accept[b]),
            .req_row   (req_row),
            .req_col   (req_col),
            .req_write (req_write),
            .grant     (grant[b]),
            .ready     (bank_ready[b]),
            .waiting   (bank_wait[b]),
            .owns_bus  (bank_owns[b]),
            .xfer      (bank_xfer[b]),
            .pre_s     (pre_strobe[b]),
            .act_s     (act_strobe[b]),
            .col_s     (col_strobe[b]),
            .col_q     (bank_col[b]),
            .wr_q      (bank_wr[b])
        );
    end

    dram_bus_arbiter #(
        .NUM_BANKS (NUM_BANKS),
        .AGE_W     (AGE_W)
    ) u_arb (
        .clk      (clk),
        .rst      (rst),
        .waiting  (bank_wait),
        .bus_free (~|bank_owns),
        .grant    (grant)
    );

    always_comb begin
        col_addr  = '0;
        bus_busy  = 1'b0;
        bus_bank  = '0;
        bus_write = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (col_strobe[b]) col_addr = col_addr | bank_col[b];
            if (bank_xfer[b]) begin
                bus_busy  = 1'b1;
                bus_bank  = BANK_W'(b);
                bus_write = bank_wr[b];
            end
        end
    end
endmodule

// File: rtl/dram_seq_checker.sv
module dram_seq_checker #(
    parameter int NUM_BANKS = 4,
    parameter int T_CAS     = 9,
    parameter int BURST     = 8,
    parameter int BANK_W    = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [NUM_BANKS-1:0] pre_strobe,
    input logic [NUM_BANKS-1:0] act_strobe,
    input logic [NUM_BANKS-1:0] col_strobe,
    input logic                 bus_busy,
    input logic [BANK_W-1:0]    bus_bank
);
    logic [15:0] since_col;

    always_ff @(posedge clk) begin
        if (rst)                    since_col <= '1;
        else if (|col_strobe)       since_col <= 16'd1;
        else if (since_col != '1)   since_col <= since_col + 16'd1;
    end

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pre_strobe == '0 && act_strobe == '0 && col_strobe == '0
                        && !bus_busy && req_ready));

    p_pre_after_accept_r3: assert property (@(posedge clk) disable iff (rst)
        (pre_strobe != '0) |-> $past(req_valid && req_ready));

    p_burst_window_r5: assert property (@(posedge clk) disable iff (rst)
        bus_busy |-> (since_col >= 16'(T_CAS) && since_col < 16'(T_CAS + BURST)));

    p_burst_owner_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_busy && $past(bus_busy)) |-> $stable(bus_bank));

    p_single_column_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(col_strobe));

    p_column_on_idle_bus_r6: assert property (@(posedge clk) disable iff (rst)
        (col_strobe != '0) |-> !bus_busy);
endmodule

bind dram_bank_sequencer dram_seq_checker #(
    .NUM_BANKS (NUM_BANKS),
    .T_CAS     (T_CAS),
    .BURST     (BURST),
    .BANK_W    (BANK_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .pre_strobe (pre_strobe),
    .act_strobe (act_strobe),
    .col_strobe (col_strobe),
    .bus_busy   (bus_busy),
    .bus_bank   (bus_bank)
);

// File: tb/tb_dram_bank_sequencer.sv
`timescale 1ns/1ps
module tb_dram_bank_sequencer;
    localparam int NB = 4;
    localparam int BW = 2;
    localparam int RW = 6;
    localparam int CW = 5;
    localparam int TP = 3;
    localparam int TA = 2;
    localparam int TC = 2;
    localparam int BL = 4;

    localparam int P_IDLE = 0, P_PRE = 1, P_ACT = 2, P_OPEN = 3,
                   P_WAIT = 4, P_COL = 5, P_XFER = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [BW-1:0] req_bank = '0;
    logic [RW-1:0] req_row = '0;
    logic [CW-1:0] req_col = '0;
    logic          req_write = 1'b0;
    logic [NB-1:0] pre_strobe, act_strobe, col_strobe;
    logic [CW-1:0] col_addr;
    logic          bus_busy;
    logic [BW-1:0] bus_bank;
    logic          bus_write;

    dram_bank_sequencer #(
        .NUM_BANKS (NB), .ROW_W (RW), .COL_W (CW),
        .T_PRE (TP), .T_ACT (TA), .T_CAS (TC), .BURST (BL), .AGE_W (8)
    ) dut (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_ready (req_ready),
        .req_bank (req_bank), .req_row (req_row), .req_col (req_col),
        .req_write (req_write), .pre_strobe (pre_strobe), .act_strobe (act_strobe),
        .col_strobe (col_strobe), .col_addr (col_addr), .bus_busy (bus_busy),
        .bus_bank (bus_bank), .bus_write (bus_write)
    );

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    int ph [NB];
    int el [NB];
    int orow [NB];
    int ocol [NB];
    bit oval [NB];
    bit owr [NB];
    int wq [$];
    int col_log [$];
    int pre_cnt = 0;
    int act_cnt = 0;
    bit overlap_seen = 1'b0;
    bit acc_flag = 1'b0;
    bit quiet = 1'b1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            for (int b = 0; b < NB; b++) begin
                ph[b] = P_IDLE; el[b] = 0; orow[b] = 0; ocol[b] = 0;
                oval[b] = 1'b0; owr[b] = 1'b0;
            end
            wq.delete();
            acc_flag = 1'b0;
            quiet = 1'b1;
        end else begin
            logic [NB-1:0] e_pre, e_act, e_col;
            int  e_addr, e_bank, g;
            bit  e_busy, e_wr, e_rdy, acc, busfree;
            e_pre = '0; e_act = '0; e_col = '0;
            e_addr = 0; e_bank = 0; e_busy = 0; e_wr = 0;
            for (int b = 0; b < NB; b++) begin
                if (ph[b] == P_PRE && el[b] == 0) e_pre[b] = 1'b1;
                if (ph[b] == P_ACT && el[b] == 0) e_act[b] = 1'b1;
                if (ph[b] == P_COL && el[b] == 0) begin e_col[b] = 1'b1; e_addr = ocol[b]; end
                if (ph[b] == P_XFER) begin e_busy = 1; e_bank = b; e_wr = owr[b]; end
            end
            e_rdy = (ph[req_bank] == P_IDLE) || (ph[req_bank] == P_OPEN);

            chk(pre_strobe == e_pre, "R3", "precharge strobes", int'(pre_strobe), int'(e_pre));
            chk(act_strobe == e_act, "R2", "activate strobes", int'(act_strobe), int'(e_act));
            chk(col_strobe == e_col, "R4 R7", "column strobes", int'(col_strobe), int'(e_col));
            chk(int'(col_addr) == e_addr, "R4", "column address", int'(col_addr), e_addr);
            chk(bus_busy == e_busy, "R5", "bus busy", int'(bus_busy), int'(e_busy));
            chk(int'(bus_bank) == e_bank, "R5", "bus bank", int'(bus_bank), e_bank);
            chk(bus_write == e_wr, "R5", "bus write", int'(bus_write), int'(e_wr));
            chk(req_ready == e_rdy, "R8", "request ready", int'(req_ready), int'(e_rdy));
            chk($countones(col_strobe) <= 1, "R6", "column strobes at once", $countones(col_strobe), 1);

            pre_cnt += $countones(pre_strobe);
            act_cnt += $countones(act_strobe);
            for (int b = 0; b < NB; b++) if (col_strobe[b]) col_log.push_back(b);
            if ((pre_strobe != '0 || act_strobe != '0) && bus_busy) overlap_seen = 1'b1;

            acc = req_valid && e_rdy;
            acc_flag = acc;

            busfree = 1'b1;
            for (int b = 0; b < NB; b++) if (ph[b] == P_COL || ph[b] == P_XFER) busfree = 1'b0;
            g = -1;
            if (busfree && wq.size() > 0) g = wq.pop_front();
            for (int b = 0; b < NB; b++) begin
                case (ph[b])
                    P_PRE:  if (el[b] == TP - 1) begin ph[b] = P_ACT; el[b] = 0; end else el[b]++;
                    P_ACT:  if (el[b] == TA - 1) begin ph[b] = P_WAIT; wq.push_back(b); end else el[b]++;
                    P_WAIT: if (b == g) begin ph[b] = P_COL; el[b] = 0; end
                    P_COL:  if (el[b] == TC - 1) begin ph[b] = P_XFER; el[b] = 0; end else el[b]++;
                    P_XFER: if (el[b] == BL - 1) ph[b] = P_OPEN; else el[b]++;
                    default: begin
                        if (acc && int'(req_bank) == b) begin
                            if (oval[b] && orow[b] == int'(req_row)) begin
                                ph[b] = P_WAIT; wq.push_back(b);
                            end else if (oval[b]) begin
                                ph[b] = P_PRE; el[b] = 0;
                            end else begin
                                ph[b] = P_ACT; el[b] = 0;
                            end
                            oval[b] = 1'b1;
                            orow[b] = int'(req_row);
                            ocol[b] = int'(req_col);
                            owr[b]  = req_write;
                        end
                    end
                endcase
            end
            quiet = 1'b1;
            for (int b = 0; b < NB; b++) if (ph[b] != P_IDLE && ph[b] != P_OPEN) quiet = 1'b0;
        end
    end

    // Called at posedge+1; returns at posedge+1 after the accepting edge.
    task automatic issue(input int b, input int row, input int col, input bit wr);
        req_valid = 1'b1;
        req_bank  = BW'(b);
        req_row   = RW'(row);
        req_col   = CW'(col);
        req_write = wr;
        forever begin
            @(negedge clk); #1;
            if (acc_flag) break;
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wait_quiet();
        do begin @(posedge clk); #1; end while (!quiet);
        idle(2);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        // R1: quiet outputs and ready after reset
        chk(pre_strobe == '0 && act_strobe == '0 && col_strobe == '0, "R1", "strobes after reset",
            int'(pre_strobe | act_strobe | col_strobe), 0);
        chk(!bus_busy, "R1", "bus idle after reset", int'(bus_busy), 0);
        chk(req_ready, "R1", "ready after reset", int'(req_ready), 1);
        @(posedge clk); #1;

        // R2: first access to idle bank opens without precharge
        issue(0, 5, 3, 1'b0);
        wait_quiet();
        chk(pre_cnt == 0, "R2", "precharges on first access", pre_cnt, 0);
        chk(act_cnt == 1, "R2", "activates on first access", act_cnt, 1);

        // R4 R10: same row again is a hit
        issue(0, 5, 7, 1'b1);
        wait_quiet();
        chk(pre_cnt == 0 && act_cnt == 1, "R4 R10", "commands on row hit", pre_cnt + act_cnt, 1);

        // R3: different row closes then opens
        issue(0, 9, 1, 1'b0);
        wait_quiet();
        chk(pre_cnt == 1, "R3", "precharges on row miss", pre_cnt, 1);
        chk(act_cnt == 2, "R3", "activates on row miss", act_cnt, 2);

        // R8: second request to a bank in mid-sequence is held
        issue(1, 1, 2, 1'b0);
        req_valid = 1'b1; req_bank = 2'd1; req_row = 6'd1; req_col = 5'd4; req_write = 1'b1;
        @(negedge clk); #1;
        chk(!req_ready, "R8", "ready while bank busy", int'(req_ready), 0);
        req_valid = 1'b0;
        @(posedge clk); #1;
        issue(1, 1, 4, 1'b1);
        issue(2, 2, 6, 1'b0);
        issue(3, 3, 8, 1'b1);
        wait_quiet();

        // R7: hits queued behind a running burst are served oldest first
        col_log.delete();
        issue(0, 9, 10, 1'b0);
        issue(3, 3, 11, 1'b1);
        issue(2, 2, 12, 1'b0);
        issue(1, 1, 13, 1'b1);
        wait_quiet();
        chk(col_log.size() == 4, "R7", "column commands issued", col_log.size(), 4);
        if (col_log.size() == 4) begin
            chk(col_log[0] == 0, "R7", "first bus owner", col_log[0], 0);
            chk(col_log[1] == 3, "R7", "second bus owner", col_log[1], 3);
            chk(col_log[2] == 2, "R7", "third bus owner", col_log[2], 2);
            chk(col_log[3] == 1, "R7", "fourth bus owner", col_log[3], 1);
        end

        // Mixed random traffic: hits, misses, contention, overlap (R9)
        for (int n = 0; n < 400; n++) begin
            issue($urandom_range(NB - 1), $urandom_range(2), $urandom_range(31), 1'($urandom_range(1)));
            idle($urandom_range(2));
        end
        wait_quiet();
        chk(overlap_seen, "R9", "close/open during another burst", int'(overlap_seen), 1);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end
endmodule